// File: doc/BRIEF.md
# Parabola-Corrected Sine Amplitude Converter

This block turns an unsigned phase word into a signed sine sample in two's complement. It uses a compressed table. Over each half cycle, the waveform is treated as a parabola plus a small correction. Only the correction is stored, indexed by the phase bits below the top bit. A single multiplier rebuilds the parabola, 4·x·(1 − x), from the same bits. The stored correction is then added to it. The top phase bit picks the half cycle and negates the result for the second half. Because the correction stays below about 6 % of full scale, the table word is four bits narrower than the output word.

Samples enter and leave on valid/ready streams. A phase word is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. The three pipeline stages advance together whenever the output slot is empty or being drained. When the consumer holds `out_ready` low with a result waiting, the whole pipeline freezes: the output and its valid flag hold, and `in_ready` drops in the same cycle. Holding `out_ready` high gives one result per clock, three clocks after acceptance.

Top module: `sinpar_conv`

## Requirements
- R1: For phase p, with P = PHASE_W and A = AMP_W, `out_amp` equals round(2^(A−1)·sin(2π·p/2^P)), clamped to ±(2^(A−1)−1), within one LSB.
- R2: Phase 0 and phase 2^(P−1), exactly half a cycle, both give exactly 0.
- R3: Phase 2^(P−2), a quarter cycle, gives exactly +(2^(A−1)−1). Phase 3·2^(P−2) gives exactly −(2^(A−1)−1).
- R4: The sum saturates and never wraps. `out_amp` is never the most negative code −2^(A−1) while `out_valid` is high.
- R5: For every p below 2^(P−1), the result for p + 2^(P−1) is the exact negation of the result for p. The top phase bit is the half-cycle select.
- R6: With `out_ready` held high, a phase accepted at one clock edge appears on `out_amp` with `out_valid` high after the third edge counted from and including that edge. `in_ready` stays high, so one phase is accepted every clock.
- R7: While `out_valid` is high and `out_ready` is low, `out_amp` and `out_valid` hold their values and `in_ready` is low. After release, results leave in acceptance order with none lost.
- R8: During and after an active-low reset on `rst_n`, and before any input, `out_valid` is 0, `out_amp` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Phase word offered |
| in_ready | output | 1 | Pipeline can take a phase word this cycle |
| in_phase | input | PHASE_W | Unsigned phase; top bit selects the half cycle |
| out_valid | output | 1 | Amplitude sample available |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_amp | output | AMP_W | Signed amplitude, two's complement |

## Verification
The bench uses the defaults: PHASE_W = 10 and AMP_W = 12, which gives an 8-bit correction table of 512 entries. At this size the full 1024-point cycle can be swept back-to-back and compared against a floating-point sine, with exact negation checked for every half-cycle pair. The quarter-cycle point lands on a parabola value of exactly 2048, so the saturation path and the peak code are reached deterministically. A forced stall with three samples in flight exercises freeze, hold and in-order release.

// File: rtl/sinpar_pkg.sv
package sinpar_pkg;

  // pi scaled by 2^28
  localparam longint PI_Q28 = 64'sd843314857;

  // round(2^(aw-1) * sin(pi * u / 2^hb)), integer-only series for elaboration
  function automatic longint sine_code(input int u, input int hb, input int aw);
    longint n, uf, th, term, acc;
    n  = longint'(1) <<< hb;
    uf = (longint'(u) > n / 2) ? n - longint'(u) : longint'(u);
    th = (PI_Q28 * uf) / n;
    term = th;
    acc  = th;
    for (int k = 1; k <= 7; k++) begin
      term = (term * th) >>> 28;
      term = (term * th) >>> 28;
      term = -term / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return ((acc <<< (aw - 1)) + (longint'(1) <<< 27)) >>> 28;
  endfunction

  // fixed-point 4*x*(1-x) at scale 2^(aw-1), same arithmetic as the datapath
  function automatic longint parab_code(input int u, input int hb, input int aw);
    longint n;
    n = longint'(1) <<< hb;
    return (longint'(u) * (n - longint'(u))) >>> (2 * hb - 2 - (aw - 1));
  endfunction

endpackage

// File: rtl/sinpar_rom.sv
module sinpar_rom #(
  parameter int HALF_W = 9,
  parameter int AMP_W  = 12,
  parameter int RES_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [HALF_W-1:0]        addr,
  output logic signed [RES_W-1:0]  res_q
);
  localparam int DEPTH = 1 << HALF_W;

  logic signed [RES_W-1:0] tbl [DEPTH];

  // sine minus parabola, one entry per phase step of the half cycle
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam longint RV = sinpar_pkg::sine_code(i, HALF_W, AMP_W)
                          - sinpar_pkg::parab_code(i, HALF_W, AMP_W);
    assign tbl[i] = RES_W'(RV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= tbl[addr];
  end
endmodule

// File: rtl/sinpar_parab.sv
module sinpar_parab #(
  parameter int HALF_W = 9,
  parameter int AMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] u,
  output logic [AMP_W-1:0]  parab_q
);
  localparam int DEPTH = 1 << HALF_W;
  localparam int PW    = 2 * HALF_W + 1;
  localparam int SH    = 2 * HALF_W - 2 - (AMP_W - 1);

  logic [HALF_W:0] cmp;
  logic [PW-1:0]   prod;

  always_comb begin
    cmp  = (HALF_W+1)'(DEPTH) - {1'b0, u};
    prod = PW'(u) * PW'(cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  parab_q <= '0;
    else if (en) parab_q <= AMP_W'(prod >> SH);
  end
endmodule

// File: rtl/sinpar_combine.sv
module sinpar_combine #(
  parameter int AMP_W = 12,
  parameter int RES_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [AMP_W-1:0]         parab_i,
  input  logic signed [RES_W-1:0]  res_i,
  input  logic                     neg_i,
  output logic signed [AMP_W-1:0]  amp_q
);
  localparam int MAXV = (1 << (AMP_W - 1)) - 1;
  localparam logic signed [AMP_W:0] MAXS = (AMP_W+1)'(MAXV);

  logic signed [AMP_W:0]   sum;
  logic        [AMP_W-1:0] mag;
  logic signed [AMP_W-1:0] amp_n;

  always_comb begin
    sum = $signed({1'b0, parab_i}) + (AMP_W+1)'(res_i);
    if (sum > MAXS)     mag = AMP_W'(MAXV);
    else if (sum < 0)   mag = '0;
    else                mag = sum[AMP_W-1:0];
    amp_n = neg_i ? -$signed(mag) : $signed(mag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  amp_q <= '0;
    else if (en) amp_q <= amp_n;
  end
endmodule

// File: rtl/sinpar_conv.sv
module sinpar_conv #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 12,
  parameter int RES_W   = AMP_W - 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PHASE_W-1:0]       in_phase,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [AMP_W-1:0]  out_amp
);
  localparam int HALF_W = PHASE_W - 1;

  logic              adv;
  logic              v1, v2, v3;
  logic [HALF_W-1:0] u1;
  logic              neg1, neg2;
  logic [AMP_W-1:0]  parab2;
  logic signed [RES_W-1:0] res2;

  // whole pipeline moves when the output slot is free or draining
  assign adv      = !v3 || out_ready;
  assign in_ready = adv;

  // stage 1: split phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; u1 <= '0; neg1 <= 1'b0;
    end else if (adv) begin
      v1   <= in_valid;
      u1   <= in_phase[HALF_W-1:0];
      neg1 <= in_phase[PHASE_W-1];
    end
  end

  // stage 2: parabola and correction in parallel
  sinpar_parab #(.HALF_W(HALF_W), .AMP_W(AMP_W)) u_parab (
    .clk(clk), .rst_n(rst_n), .en(adv), .u(u1), .parab_q(parab2)
  );

  sinpar_rom #(.HALF_W(HALF_W), .AMP_W(AMP_W), .RES_W(RES_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(adv), .addr(u1), .res_q(res2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; neg2 <= 1'b0;
    end else if (adv) begin
      v2 <= v1; neg2 <= neg1;
    end
  end

  // stage 3: sum, clamp, sign
  sinpar_combine #(.AMP_W(AMP_W), .RES_W(RES_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(adv), .parab_i(parab2), .res_i(res2),
    .neg_i(neg2), .amp_q(out_amp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   v3 <= 1'b0;
    else if (adv) v3 <= v2;
  end

  assign out_valid = v3;
endmodule

// File: rtl/sinpar_conv_chk.sv
module sinpar_conv_chk #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_ready,
  input  logic [PHASE_W-2:0]      in_low,
  input  logic                    out_valid,
  input  logic                    out_ready,
  input  logic signed [AMP_W-1:0] out_amp
);
  localparam logic signed [AMP_W-1:0] MINC = {1'b1, {(AMP_W-1){1'b0}}};

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 3)  age <= age + 2'd1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_amp));

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  // R4
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_amp != MINC);

  // R6
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && $past(in_valid && in_ready, 3) && $past(in_ready, 2)
    && $past(in_ready, 1) |-> out_valid);

  // R2
  zero_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && $past(in_valid && in_ready && (in_low == '0), 3)
    && $past(in_ready, 2) && $past(in_ready, 1) |-> out_amp == '0);
endmodule

bind sinpar_conv sinpar_conv_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_low(in_phase[PHASE_W-2:0]), .out_valid(out_valid),
  .out_ready(out_ready), .out_amp(out_amp)
);

// File: tb/sim_sinpar_conv.sv
module sim_sinpar_conv;
  localparam int PERIOD  = 10;
  localparam int PHASE_W = 10;
  localparam int AMP_W   = 12;
  localparam int NPH     = 1 << PHASE_W;
  localparam int HALF    = NPH / 2;
  localparam int MAXV    = (1 << (AMP_W - 1)) - 1;

  // phase, expected amplitude (R1, tolerance one LSB)
  localparam int NV = 10;
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{85, 1020}, '{128, 1448}, '{171, 1776}, '{256, 2047},
    '{384, 1448}, '{512, 0}, '{640, -1448}, '{768, -2047}, '{896, -1448}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PHASE_W-1:0] in_phase = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [AMP_W-1:0] out_amp;

  int checks = 0;
  int errors = 0;
  int stalls = 0;
  int got [$];
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sinpar_conv #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_amp(out_amp)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(int'(out_amp));

  function automatic int model(input int p);
    real v;
    int r;
    v = 2048.0 * $sin(2.0 * 3.14159265358979 * real'(p) / real'(NPH));
    r = $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    if (r > MAXV) r = MAXV;
    if (r < -MAXV) r = -MAXV;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a rising edge; returns just after a rising edge
  task automatic send(input int p);
    bit ok;
    in_valid = 1'b1;
    in_phase = PHASE_W'(p);
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      ok = in_ready;
      if (!ok) stalls++;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    while (got.size() < n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 out_valid", int'(out_valid), 0, 0);
    chk("R8 out_amp", int'(out_amp), 0, 0);
    chk("R8 in_ready", int'(in_ready), 1, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after release", int'(out_valid), 0, 0);
    @(posedge clk); #1;

    // R1 vector table
    got.delete();
    for (int i = 0; i < NV; i++) send(VEC[i][0]);
    wait_n(NV);
    for (int i = 0; i < NV; i++) chk("R1 vector", got[i], VEC[i][1], 1);

    // R1 R4 R5 R6 full sweep back-to-back
    @(posedge clk); #1;
    got.delete();
    stalls = 0;
    for (int p = 0; p < NPH; p++) send(p);
    chk("R6 no stall at full rate", stalls, 0, 0);
    wait_n(NPH);
    for (int p = 0; p < NPH; p++) begin
      chk("R1 sweep", got[p], model(p), 1);
      if (got[p] == -(MAXV + 1)) chk("R4 min code", got[p], -MAXV, 0);
    end
    for (int p = 0; p < HALF; p++) chk("R5 negated half", got[p + HALF], -got[p], 0);

    // R2 R3 exact points
    chk("R2 phase zero", got[0], 0, 0);
    chk("R2 half cycle", got[HALF], 0, 0);
    chk("R3 quarter", got[NPH/4], MAXV, 0);
    chk("R3 three quarter", got[3*NPH/4], -MAXV, 0);
    chk("R4 saturation clamp", got[NPH/4], 2047, 0);

    // R6 latency
    @(posedge clk); #1;
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_phase = PHASE_W'(NPH/4);
    @(negedge clk);
    chk("R6 accepted", int'(in_ready), 1, 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not early", int'(out_valid), 0, 0);
    @(negedge clk);
    chk("R6 valid at third edge", int'(out_valid), 1, 0);
    chk("R6 value", int'(out_amp), MAXV, 0);
    @(posedge clk); #1;

    // R7 back-pressure
    got.delete();
    out_ready = 1'b0;
    fork
      begin
        send(100); send(200); send(300); send(400); send(500);
      end
      begin
        repeat (6) @(negedge clk);
        a = int'(out_amp);
        chk("R7 held valid", int'(out_valid), 1, 0);
        chk("R7 ready low", int'(in_ready), 0, 0);
        chk("R7 head value", a, model(100), 1);
        repeat (3) @(negedge clk);
        chk("R7 stable amp", int'(out_amp), a, 0);
        chk("R7 no output taken", got.size(), 0, 0);
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    wait_n(5);
    chk("R7 order 100", got[0], model(100), 1);
    chk("R7 order 200", got[1], model(200), 1);
    chk("R7 order 300", got[2], model(300), 1);
    chk("R7 order 400", got[3], model(400), 1);
    chk("R7 order 500", got[4], model(500), 1);

    repeat (4) @(negedge clk);
    chk("R7 drained", int'(out_valid), 0, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule